// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block keeps time in whole seconds. A slow tick strobe from elsewhere on the chip feeds a reloadable 20-bit down-counting divider. Each time the divider passes through zero it reloads and emits a one-cycle second step. The step advances a 32-bit seconds count, and the count is compared against a 32-bit alarm value. With a reload of 0x7FFF and a 32.768 kHz tick, the count advances once per second. A 16-bit register bus with a 4-bit word address and single-cycle writes reaches every register. Reads are combinational.

The reload, count and alarm registers are guarded. Writing `1` to the configure bit opens a configuration session. Inside the session, writes to those registers go into staging copies. Clearing the configure bit closes the session and starts a commit window of a fixed number of cycles (four by default). During the window the ready bit reads 0. At the end of the window the staged values replace the live ones. A committed count or reload also restarts the divider from the new reload value.

Three event flags record a second step, an alarm match and a count wrap. Each flag has its own enable bit, and the interrupt output combines them.

The session controller has three states:
- **RUN**: normal operation. A write of `1` to the configure bit (transition *open*) moves to **CFG** and snapshots the live values into staging.
- **CFG**: guarded writes go to staging. A write of `0` to the configure bit (transition *close*) moves to **COMMIT**.
- **COMMIT**: waits out the commit window. On its last cycle (transition *apply*) it writes the staged values and returns to **RUN**.

Register map (word address: content):
- 0, control low: bits 2:0 hold the flags {wrap, alarm, second}. Bit 4 is the configure bit. Bit 5 is the read-only ready bit.
- 1, control high: bits 2:0 hold the enables, in the same order as the flags.
- 2, reload high: bits 3:0 hold reload bits 19:16.
- 3, reload low: reload bits 15:0.
- 4, divider high (read-only): live divider bits 19:16 in bits 3:0.
- 5, divider low (read-only): live divider bits 15:0.
- 6, count high: count bits 31:16.
- 7, count low: count bits 15:0.
- 8, alarm high: alarm bits 31:16.
- 9, alarm low: alarm bits 15:0.

Top module: `sec_rtc`

## Requirements
- R1: After reset the block holds these values. Control low reads 0x0020 (ready 1, configure 0, flags 0). Control high reads 0. The reload reads 0x7FFF and the divider reads 0x7FFF. The count reads 0 and the alarm reads 0xFFFFFFFF. irq_o is 0.
- R2: Writes to address 2, 3, 6, 7, 8 or 9 have no effect on the readback while the configure bit (control low bit 4) is 0.
- R3: A write to control low with bit 4 set opens a session, and bit 4 then reads 1. Guarded writes made inside the session are invisible until the session is closed. Closing the session (a write with bit 4 clear) makes the ready bit (bit 5) read 0 for exactly four cycles after the write edge. On the next cycle the ready bit reads 1 and the staged values are visible.
- R4: A write to control low that would open a session is ignored while the ready bit is 0, so bit 4 still reads 0 after the window ends.
- R5: The divider counts down by one on each tick. When a tick arrives with the divider at 0, the divider reloads and the count increments. One second therefore spans reload+1 ticks.
- R6: The second flag (control low bit 0) is set by every divider rollover.
- R7: The alarm flag (bit 1) is set when an increment makes the count equal to the alarm. Committing a count equal to the alarm does not set the flag.
- R8: When the count steps from 0xFFFFFFFF to 0, the wrap flag (bit 2) is set.
- R9: A write to control low clears each flag whose bit is written 0 and leaves each flag whose bit is written 1 unchanged. This works outside a session. An event arriving in the same cycle as the clear wins, and the flag stays set.
- R10: irq_o is 1 exactly when some flag is set and its enable bit (control high, same bit position) is 1. The enables can be written at any time.
- R11: Committing a new count or reload loads the divider with the reload value in force after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow tick strobe, one per divider step |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined enabled-flag interrupt |

## Verification
The hardest case to reach from the ports is a software flag clear landing on the very edge where a second step sets the same flag. To get there, the divider is first run to zero with counted ticks and read back until it shows 0. Then the clear write and a single tick strobe are raised on the same falling edge. A second hard case is the commit window itself. An open request is issued inside the window, and the ready bit is sampled after each of the four edges that follow the closing write.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int ADDR_W = 4;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_RLD_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] A_RLD_LO  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIV_HI  = 4'd4;
    localparam logic [ADDR_W-1:0] A_DIV_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd7;
    localparam logic [ADDR_W-1:0] A_ALM_HI  = 4'd8;
    localparam logic [ADDR_W-1:0] A_ALM_LO  = 4'd9;

    // flag / enable bit positions
    localparam int FLAG_SEC  = 0;
    localparam int FLAG_ALM  = 1;
    localparam int FLAG_WRAP = 2;
    localparam int NUM_FLAGS = 3;

    // control-low bit positions
    localparam int CFG_BIT   = 4;
    localparam int READY_BIT = 5;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_CFG    = 2'd1,
        ST_COMMIT = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int               DIV_W   = 20,
    parameter logic [DIV_W-1:0] RLD_RST = 20'h07FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] load_val_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic [DIV_W-1:0] div_o,
    output logic             roll_o
);

    localparam logic [DIV_W-1:0] ONE_D = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] div_q;
    logic             at_zero;

    assign at_zero = (div_q == '0);
    assign roll_o  = tick_i && at_zero && !load_i;
    assign div_o   = div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= RLD_RST;
        end else if (load_i) begin
            div_q <= load_val_i;
        end else if (tick_i) begin
            div_q <= at_zero ? reload_i : (div_q - ONE_D);
        end
    end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] alarm_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             alarm_hit_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc     = cnt_q + ONE_C;
    assign alarm_hit_o = step_i && (cnt_inc == alarm_i);
    assign wrap_o      = step_i && (&cnt_q);
    assign cnt_o       = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (step_i) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/sec_rtc_cfg_fsm.sv
module sec_rtc_cfg_fsm
    import sec_rtc_pkg::*;
#(
    parameter int               BUS_W      = 16,
    parameter int               DIV_W      = 20,
    parameter int               CNT_W      = 32,
    parameter int               COMMIT_LAT = 4,
    parameter logic [DIV_W-1:0] RLD_RST    = 20'h07FFF,
    parameter logic [CNT_W-1:0] ALM_RST    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              cfg_o,
    output logic              ready_o,
    output logic [DIV_W-1:0]  rld_o,
    output logic [CNT_W-1:0]  alm_o,
    output logic              cnt_load_o,
    output logic [CNT_W-1:0]  cnt_val_o,
    output logic              div_load_o,
    output logic [DIV_W-1:0]  div_val_o
);

    localparam int                WAIT_W   = $clog2(COMMIT_LAT + 1);
    localparam int                RLD_HI_W = DIV_W - BUS_W;
    localparam logic [WAIT_W-1:0] LAST     = WAIT_W'(COMMIT_LAT - 1);
    localparam logic [WAIT_W-1:0] ONE_W    = WAIT_W'(1);

    cfg_state_e        state_q, state_d;
    logic [WAIT_W-1:0] wait_q;
    logic [DIV_W-1:0]  st_rld, rld_q;
    logic [CNT_W-1:0]  st_cnt, st_alm, alm_q;
    logic              pend_rld, pend_cnt, pend_alm;
    logic              wr_ctl, req_open, req_close, apply_now;

    assign wr_ctl    = wr_i && (addr_i == A_CTRL_LO);
    assign req_open  = wr_ctl && wdata_i[CFG_BIT];
    assign req_close = wr_ctl && !wdata_i[CFG_BIT];
    assign apply_now = (state_q == ST_COMMIT) && (wait_q == LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (req_open)  state_d = ST_CFG;
            ST_CFG:    if (req_close) state_d = ST_COMMIT;
            ST_COMMIT: if (apply_now) state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // commit window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wait_q <= '0;
        else if (state_q != ST_COMMIT)  wait_q <= '0;
        else if (!apply_now)            wait_q <= wait_q + ONE_W;
    end

    // staging copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_rld   <= RLD_RST;
            st_cnt   <= '0;
            st_alm   <= ALM_RST;
            pend_rld <= 1'b0;
            pend_cnt <= 1'b0;
            pend_alm <= 1'b0;
        end else if (state_q == ST_RUN && req_open) begin
            st_rld   <= rld_q;
            st_cnt   <= cnt_i;
            st_alm   <= alm_q;
            pend_rld <= 1'b0;
            pend_cnt <= 1'b0;
            pend_alm <= 1'b0;
        end else if (state_q == ST_CFG && wr_i) begin
            case (addr_i)
                A_RLD_HI: begin
                    st_rld[DIV_W-1:BUS_W] <= wdata_i[RLD_HI_W-1:0];
                    pend_rld <= 1'b1;
                end
                A_RLD_LO: begin
                    st_rld[BUS_W-1:0] <= wdata_i;
                    pend_rld <= 1'b1;
                end
                A_CNT_HI: begin
                    st_cnt[CNT_W-1:BUS_W] <= wdata_i;
                    pend_cnt <= 1'b1;
                end
                A_CNT_LO: begin
                    st_cnt[BUS_W-1:0] <= wdata_i;
                    pend_cnt <= 1'b1;
                end
                A_ALM_HI: begin
                    st_alm[CNT_W-1:BUS_W] <= wdata_i;
                    pend_alm <= 1'b1;
                end
                A_ALM_LO: begin
                    st_alm[BUS_W-1:0] <= wdata_i;
                    pend_alm <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // live reload and alarm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q <= RLD_RST;
            alm_q <= ALM_RST;
        end else if (apply_now) begin
            if (pend_rld) rld_q <= st_rld;
            if (pend_alm) alm_q <= st_alm;
        end
    end

    // outputs
    always_comb begin
        cfg_o      = (state_q == ST_CFG);
        ready_o    = (state_q != ST_COMMIT);
        rld_o      = rld_q;
        alm_o      = alm_q;
        cnt_load_o = apply_now && pend_cnt;
        cnt_val_o  = st_cnt;
        div_load_o = apply_now && (pend_cnt || pend_rld);
        div_val_o  = pend_rld ? st_rld : rld_q;
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int               BUS_W      = 16,
    parameter int               DIV_W      = 20,
    parameter int               CNT_W      = 32,
    parameter int               COMMIT_LAT = 4,
    parameter logic [DIV_W-1:0] RLD_RST    = 20'h07FFF,
    parameter logic [CNT_W-1:0] ALM_RST    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o
);

    localparam int RLD_HI_W = DIV_W - BUS_W;
    localparam int PAD_W    = BUS_W - RLD_HI_W;
    localparam int CTL_PAD  = BUS_W - READY_BIT - 1;
    localparam int EN_PAD   = BUS_W - NUM_FLAGS;

    logic                 cfg_w, ready_w;
    logic [DIV_W-1:0]     rld_w, div_w, div_val_w;
    logic [CNT_W-1:0]     cnt_w, alm_w, cnt_val_w;
    logic                 cnt_load_w, div_load_w, roll_w;
    logic                 alarm_hit_w, wrap_w;
    logic [NUM_FLAGS-1:0] evt_w, flags_w;
    logic [NUM_FLAGS-1:0] en_q;
    logic                 wr_ctl, wr_en;

    assign wr_ctl = bus_wr_i && (bus_addr_i == A_CTRL_LO);
    assign wr_en  = bus_wr_i && (bus_addr_i == A_CTRL_HI);

    sec_rtc_cfg_fsm #(
        .BUS_W      (BUS_W),
        .DIV_W      (DIV_W),
        .CNT_W      (CNT_W),
        .COMMIT_LAT (COMMIT_LAT),
        .RLD_RST    (RLD_RST),
        .ALM_RST    (ALM_RST)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .cnt_i      (cnt_w),
        .cfg_o      (cfg_w),
        .ready_o    (ready_w),
        .rld_o      (rld_w),
        .alm_o      (alm_w),
        .cnt_load_o (cnt_load_w),
        .cnt_val_o  (cnt_val_w),
        .div_load_o (div_load_w),
        .div_val_o  (div_val_w)
    );

    sec_rtc_prescaler #(
        .DIV_W   (DIV_W),
        .RLD_RST (RLD_RST)
    ) psc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (div_load_w),
        .load_val_i (div_val_w),
        .reload_i   (rld_w),
        .div_o      (div_w),
        .roll_o     (roll_w)
    );

    sec_rtc_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (roll_w),
        .load_i      (cnt_load_w),
        .load_val_i  (cnt_val_w),
        .alarm_i     (alm_w),
        .cnt_o       (cnt_w),
        .alarm_hit_o (alarm_hit_w),
        .wrap_o      (wrap_w)
    );

    assign evt_w[FLAG_SEC]  = roll_w;
    assign evt_w[FLAG_ALM]  = alarm_hit_w;
    assign evt_w[FLAG_WRAP] = wrap_w;

    // event flags: set wins over a same-cycle clear
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          flag_q <= 1'b0;
            else if (evt_w[g])                   flag_q <= 1'b1;
            else if (wr_ctl && !bus_wdata_i[g])  flag_q <= 1'b0;
        end
        assign flags_w[g] = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= bus_wdata_i[NUM_FLAGS-1:0];
    end

    assign irq_o = |(flags_w & en_q);

    always_comb begin
        case (bus_addr_i)
            A_CTRL_LO: bus_rdata_o = {{CTL_PAD{1'b0}}, ready_w, cfg_w, 1'b0, flags_w};
            A_CTRL_HI: bus_rdata_o = {{EN_PAD{1'b0}}, en_q};
            A_RLD_HI:  bus_rdata_o = {{PAD_W{1'b0}}, rld_w[DIV_W-1:BUS_W]};
            A_RLD_LO:  bus_rdata_o = rld_w[BUS_W-1:0];
            A_DIV_HI:  bus_rdata_o = {{PAD_W{1'b0}}, div_w[DIV_W-1:BUS_W]};
            A_DIV_LO:  bus_rdata_o = div_w[BUS_W-1:0];
            A_CNT_HI:  bus_rdata_o = cnt_w[CNT_W-1:BUS_W];
            A_CNT_LO:  bus_rdata_o = cnt_w[BUS_W-1:0];
            A_ALM_HI:  bus_rdata_o = alm_w[CNT_W-1:BUS_W];
            A_ALM_LO:  bus_rdata_o = alm_w[BUS_W-1:0];
            default:   bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc_sva.sv
module sec_rtc_sva #(
    parameter int DIV_W      = 20,
    parameter int CNT_W      = 32,
    parameter int NUM_FLAGS  = 3,
    parameter int COMMIT_LAT = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_i,
    input logic                 ready_i,
    input logic                 cfg_i,
    input logic                 div_load_i,
    input logic                 cnt_load_i,
    input logic                 roll_i,
    input logic [DIV_W-1:0]     div_i,
    input logic [CNT_W-1:0]     cnt_i,
    input logic [CNT_W-1:0]     alarm_i,
    input logic [NUM_FLAGS-1:0] flags_i
);

    localparam logic [DIV_W-1:0] ONE_D  = {{(DIV_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ONE_C  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam int               RUN_W  = $clog2(COMMIT_LAT + 2);
    localparam logic [RUN_W-1:0] LAT_R  = RUN_W'(COMMIT_LAT);
    localparam logic [RUN_W-1:0] ONE_R  = RUN_W'(1);

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           busy_run <= '0;
        else if (ready_i)     busy_run <= '0;
        else if (busy_run != LAT_R) busy_run <= busy_run + ONE_R;
    end

    // R3: the commit window never lasts longer than its latency
    assert_commit_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> (busy_run < LAT_R));

    // R4: no session can be opened while the commit is pending
    assert_no_open_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> !cfg_i);

    // R2: without a commit the count only holds or steps by one
    assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_load_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + ONE_C));

    // R5: a tick on a nonzero divider decrements it
    assert_div_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (div_i != '0) && !div_load_i) |=> (div_i == $past(div_i) - ONE_D));

    // R6: every rollover leaves the second flag set
    assert_sec_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        roll_i |=> flags_i[0]);

    // R7: stepping onto the alarm value sets the alarm flag
    assert_alarm_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_i && ((cnt_i + ONE_C) == alarm_i)) |=> flags_i[1]);

    // R8: stepping from all ones lands on zero with the wrap flag set
    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_i && (&cnt_i)) |=> (flags_i[2] && (cnt_i == '0)));

endmodule

bind sec_rtc sec_rtc_sva #(
    .DIV_W      (DIV_W),
    .CNT_W      (CNT_W),
    .NUM_FLAGS  (sec_rtc_pkg::NUM_FLAGS),
    .COMMIT_LAT (COMMIT_LAT)
) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .ready_i    (ready_w),
    .cfg_i      (cfg_w),
    .div_load_i (div_load_w),
    .cnt_load_i (cnt_load_w),
    .roll_i     (roll_w),
    .div_i      (div_w),
    .cnt_i      (cnt_w),
    .alarm_i    (alm_w),
    .flags_i    (flags_w)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sec_rtc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    localparam logic [3:0] CL = 4'd0, CH = 4'd1, RH = 4'd2, RL = 4'd3, DH = 4'd4,
                           DL = 4'd5, NH = 4'd6, NL = 4'd7, AH = 4'd8, AL = 4'd9;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd32(input logic [3:0] ah, input logic [3:0] al, output logic [31:0] d);
        logic [15:0] h, l;
        rd(ah, h);
        rd(al, l);
        d = {h, l};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic open_cfg();
        wr(CL, 16'h0017);
    endtask

    task automatic close_cfg();
        wr(CL, 16'h0007);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_R1();
        logic [31:0] v;
        logic [15:0] h;
        rd(CL, h);        chk("R1", "ctrl_lo", {16'd0, h}, 32'h0020);
        rd(CH, h);        chk("R1", "ctrl_hi", {16'd0, h}, 32'h0);
        rd32(RH, RL, v);  chk("R1", "reload", v, 32'h7FFF);
        rd32(DH, DL, v);  chk("R1", "divider", v, 32'h7FFF);
        rd32(NH, NL, v);  chk("R1", "count", v, 32'h0);
        rd32(AH, AL, v);  chk("R1", "alarm", v, 32'hFFFFFFFF);
        chk("R1", "irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_locked_R2();
        logic [31:0] v;
        wr(NL, 16'h0005); wr(AL, 16'h1234); wr(RL, 16'h0003); wr(NH, 16'h00AA);
        rd32(NH, NL, v);  chk("R2", "count locked", v, 32'h0);
        rd32(AH, AL, v);  chk("R2", "alarm locked", v, 32'hFFFFFFFF);
        rd32(RH, RL, v);  chk("R2", "reload locked", v, 32'h7FFF);
    endtask

    task automatic t_one_second_R5();
        logic [31:0] v;
        logic [15:0] h;
        ticks(32767);
        rd32(NH, NL, v);  chk("R5", "count before rollover", v, 32'h0);
        rd32(DH, DL, v);  chk("R5", "divider at zero", v, 32'h0);
        ticks(1);
        rd32(NH, NL, v);  chk("R5", "count after reload+1 ticks", v, 32'h1);
        rd32(DH, DL, v);  chk("R5", "divider reloaded", v, 32'h7FFF);
        rd(CL, h);        chk("R6", "second flag", {31'd0, h[0]}, 32'h1);
    endtask

    task automatic t_commit_R3();
        logic [31:0] v;
        logic [15:0] h;
        open_cfg();
        rd(CL, h);        chk("R3", "configure bit", {31'd0, h[4]}, 32'h1);
        wr(RH, 16'h0000); wr(RL, 16'h0003);
        wr(NH, 16'h0000); wr(NL, 16'h000A);
        wr(AH, 16'h0000); wr(AL, 16'h000C);
        rd32(NH, NL, v);  chk("R3", "count staged only", v, 32'h1);
        rd32(RH, RL, v);  chk("R3", "reload staged only", v, 32'h7FFF);
        wr(CL, 16'h0007);
        for (int i = 0; i < 4; i++) begin
            rd(CL, h);    chk("R3", "ready low in window", {31'd0, h[5]}, 32'h0);
            @(negedge clk);
        end
        rd(CL, h);        chk("R3", "ready back", {31'd0, h[5]}, 32'h1);
        rd32(NH, NL, v);  chk("R3", "count committed", v, 32'hA);
        rd32(RH, RL, v);  chk("R3", "reload committed", v, 32'h3);
        rd32(AH, AL, v);  chk("R3", "alarm committed", v, 32'hC);
        rd32(DH, DL, v);  chk("R11", "divider restarted", v, 32'h3);
    endtask

    task automatic t_busy_R4();
        logic [15:0] h;
        open_cfg();
        wr(CL, 16'h0007);
        wr(CL, 16'h0017);
        repeat (4) @(negedge clk);
        rd(CL, h);
        chk("R4", "open ignored while busy", {30'd0, h[5], h[4]}, 32'h2);
    endtask

    task automatic t_clear_R9();
        logic [15:0] h;
        wr(CL, 16'h0006);
        rd(CL, h);        chk("R9", "second flag cleared", {29'd0, h[2:0]}, 32'h0);
    endtask

    task automatic t_prescale_R5();
        logic [31:0] v;
        logic [15:0] h;
        ticks(2);
        rd32(DH, DL, v);  chk("R5", "divider after 2 ticks", v, 32'h1);
        ticks(1);
        rd32(NH, NL, v);  chk("R5", "count held", v, 32'hA);
        ticks(1);
        rd32(NH, NL, v);  chk("R5", "count stepped", v, 32'hB);
        rd32(DH, DL, v);  chk("R5", "divider reload 3", v, 32'h3);
        rd(CL, h);        chk("R6", "second flag again", {31'd0, h[0]}, 32'h1);
    endtask

    task automatic t_alarm_R7();
        logic [31:0] v;
        logic [15:0] h;
        ticks(4);
        rd32(NH, NL, v);  chk("R7", "count at alarm", v, 32'hC);
        rd(CL, h);        chk("R7", "alarm flag set", {31'd0, h[1]}, 32'h1);
        wr(CL, 16'h0000);
        open_cfg();
        wr(NH, 16'h0000); wr(NL, 16'h0014);
        wr(AH, 16'h0000); wr(AL, 16'h0014);
        close_cfg();
        rd(CL, h);        chk("R7", "commit equal no alarm", {29'd0, h[2:0]}, 32'h0);
        ticks(4);
        rd(CL, h);        chk("R7", "step past alarm no flag", {31'd0, h[1]}, 32'h0);
    endtask

    task automatic t_wrap_R8();
        logic [31:0] v;
        logic [15:0] h;
        wr(CL, 16'h0000);
        open_cfg();
        wr(NH, 16'hFFFF); wr(NL, 16'hFFFF);
        close_cfg();
        ticks(4);
        rd32(NH, NL, v);  chk("R8", "count wrapped", v, 32'h0);
        rd(CL, h);        chk("R8", "flags after wrap", {29'd0, h[2:0]}, 32'h5);
    endtask

    task automatic t_irq_R10();
        logic [15:0] h;
        wr(CH, 16'h0000); chk("R10", "irq no enables", {31'd0, irq}, 32'h0);
        wr(CH, 16'h0002); chk("R10", "irq alarm-only enable", {31'd0, irq}, 32'h0);
        wr(CH, 16'h0004); chk("R10", "irq wrap enable", {31'd0, irq}, 32'h1);
        wr(CL, 16'h0003);
        rd(CL, h);        chk("R9", "write 1 keeps, 0 clears", {29'd0, h[2:0]}, 32'h1);
        chk("R10", "irq after clear", {31'd0, irq}, 32'h0);
        wr(CH, 16'h0001); chk("R10", "irq second enable", {31'd0, irq}, 32'h1);
        wr(CH, 16'h0000);
    endtask

    task automatic t_restart_R11();
        logic [31:0] v;
        ticks(2);
        rd32(DH, DL, v);  chk("R11", "divider mid count", v, 32'h1);
        open_cfg();
        wr(NL, 16'h0040);
        close_cfg();
        rd32(NH, NL, v);  chk("R11", "count only commit", v, 32'h40);
        rd32(DH, DL, v);  chk("R11", "divider restart on count", v, 32'h3);
        ticks(1);
        open_cfg();
        wr(RL, 16'h0005);
        close_cfg();
        rd32(DH, DL, v);  chk("R11", "divider restart on reload", v, 32'h5);
    endtask

    task automatic t_race_R9();
        logic [31:0] v;
        logic [15:0] h;
        wr(CL, 16'h0000);
        ticks(5);
        rd32(DH, DL, v);  chk("R9", "divider at zero before race", v, 32'h0);
        @(negedge clk);
        tick = 1'b1; bus_addr = CL; bus_wdata = 16'h0006; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(CL, h);        chk("R9", "set beats clear", {31'd0, h[0]}, 32'h1);
        rd32(NH, NL, v);  chk("R9", "count stepped in race", v, 32'h41);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_locked_R2();
        t_one_second_R5();
        t_commit_R3();
        t_busy_R4();
        t_clear_R9();
        t_prescale_R5();
        t_alarm_R7();
        t_wrap_R8();
        t_irq_R10();
        t_restart_R11();
        t_race_R9();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule